// File: doc/BRIEF.md
# Linked-Segment Instruction Queue Fetcher

This block walks one instruction queue that lives in memory as a chain of segments. Software grants fetch credit by writing 64-bit word counts to a doorbell. The block turns that credit into 64-byte line reads at a running line address, one 8-word instruction per read, and hands each assembled instruction to the execution side. The execution side acknowledges it when done.

A segment of `8n+1` words carries `n` instructions followed by one link word. Once `n` instructions of a segment are consumed, the block reads the link word and jumps to the segment it names. Software keeps a view of the pending credit, the next line to be fetched and the number of instructions in flight. It may reload the start address only while the queue is disabled and nothing is in flight.

Top module: `iqfetch_ctrl`

## Requirements
- R1: After reset, `pend_cnt`, `db_ovf`, `inflight`, `next_line`, `req_valid`, `ins_valid` and `rd_err` are all zero.
- R2: A doorbell write adds `db_val` to `pend_cnt`. Each accepted instruction request (`req_valid && req_ready && !req_ptr`) lowers it by 8 in that same cycle. Both can occur together.
- R3: When the doorbell sum exceeds 2^20-1, `pend_cnt` keeps the low 20 bits and `db_ovf` is set. The flag stays set until `ovf_clr`, and a new overflow in the clear cycle leaves it set.
- R4: A read starts only when, in the cycle before `req_valid` rises, `enable` was high and `pend_cnt` was at least 8. An instruction read also needs `inflight` below 255.
- R5: An instruction read addresses line `next_line`. When its last beat arrives, `next_line` advances by one line of 64 bytes.
- R6: With `seg_words` = 8n+1, the read after the n-th instruction of a segment has `req_ptr`=1 at the following line. Bits 48:6 of that response become `next_line`, the other bits are ignored, and the segment instruction count restarts.
- R7: An instruction arrives as 8 response beats. Beat k lands in `ins_data[64k+63:64k]`, and `ins_valid` pulses for one cycle in the cycle after the last beat.
- R8: `rd_err` pulses in the cycle after any response beat with `rsp_err` set. An errored instruction is not delivered, but its line is still consumed. An errored link response leaves `next_line` unchanged and the link read is issued again.
- R9: `inflight` rises by one per accepted instruction request. It falls by one per `ins_done` (ignored at zero) and by one when an errored instruction completes.
- R10: `base_wr` loads `base_line` into `next_line` and restarts the segment count. It is used only while `enable` is low and `inflight` is zero.
- R11: A raised `req_valid` holds, with `req_line` and `req_ptr` unchanged, until `req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Queue enable |
| seg_words | input | 13 | Segment size in 64-bit words (8n+1) |
| base_wr | input | 1 | Load start line |
| base_line | input | 43 | Start address bits 48:6 |
| db_wr | input | 1 | Doorbell write strobe |
| db_val | input | 20 | Words added by the doorbell (multiple of 8) |
| ovf_clr | input | 1 | Clears the doorbell overflow flag |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_ptr | output | 1 | 1 = link-word read (1 beat), 0 = instruction read (8 beats) |
| req_line | output | 43 | Read line address (bits 48:6) |
| rsp_valid | input | 1 | Response beat valid |
| rsp_data | input | 64 | Response beat data |
| rsp_err | input | 1 | Response beat carries an error |
| ins_valid | output | 1 | Assembled instruction pulse |
| ins_data | output | 512 | Instruction, word 0 in the low bits |
| ins_done | input | 1 | Execution side retires one instruction |
| pend_cnt | output | 20 | Pending doorbell words |
| next_line | output | 43 | Next line to be fetched |
| inflight | output | 8 | Instructions fetched and not yet retired |
| db_ovf | output | 1 | Sticky doorbell overflow |
| rd_err | output | 1 | Read error pulse |

## Verification
The assertions assume that doorbell values are multiples of 8. They also assume the start line is reloaded only while the queue is disabled and idle, and that response beats arrive only for a read that was issued, never ahead of it. The stimulus writes doorbells only in multiples of 8 and disables the queue before each reload. Before a reload it also waits for the in-flight count to drain through `ins_done`. Its memory responder answers strictly one request at a time, with a fixed delay and with gaps between beats.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_INS_REQ = 3'd1,
    ST_INS_RSP = 3'd2,
    ST_LNK_REQ = 3'd3,
    ST_LNK_RSP = 3'd4
  } fetch_st_e;
endpackage

// File: rtl/iqf_credit.sv
module iqf_credit #(
  parameter int CNT_W     = 20,
  parameter int INS_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_wr,
  input  logic [CNT_W-1:0] db_val,
  input  logic             take,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             has_ins
);
  localparam logic [CNT_W:0] TAKE_AMT = (CNT_W+1)'(INS_WORDS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   add_v, sum_v;
  logic             ovf_q, ovf_d, cnt_en, ovf_en;

  always_comb begin
    add_v  = db_wr ? {1'b0, db_val} : '0;
    sum_v  = {1'b0, cnt_q} + add_v - (take ? TAKE_AMT : '0);
    cnt_d  = sum_v[CNT_W-1:0];
    cnt_en = db_wr | take;
    ovf_d  = db_wr & sum_v[CNT_W];
    ovf_en = ovf_d | ovf_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (ovf_en) ovf_q <= ovf_d;
    end
  end

  assign cnt     = cnt_q;
  assign ovf     = ovf_q;
  assign has_ins = (cnt_q >= CNT_W'(INS_WORDS));

  AST_DB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    db_wr |-> (db_val[2:0] == 3'b000)); // R2
  AST_TAKE_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cnt_q >= CNT_W'(INS_WORDS))); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q); // R3
endmodule

// File: rtl/iqf_inflight.sv
module iqf_inflight #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec_done,
  input  logic             dec_err,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  localparam logic [CNT_W-1:0] MAX_CNT = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   up_v, dn_v;
  logic             cnt_en;

  always_comb begin
    up_v   = {1'b0, cnt_q} + (CNT_W+1)'(inc);
    dn_v   = (CNT_W+1)'(dec_done && (cnt_q != '0)) + (CNT_W+1)'(dec_err);
    cnt_d  = (up_v > dn_v) ? CNT_W'(up_v - dn_v) : '0;
    cnt_en = inc | dec_done | dec_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign full = (cnt_q == MAX_CNT);

  AST_INFL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX_CNT) |=> (cnt_q != '0)); // R9
  AST_INFL_NO_INC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX_CNT) |-> !inc); // R4
endmodule

// File: rtl/iqf_assemble.sv
module iqf_assemble #(
  parameter int WORD_W    = 64,
  parameter int INS_WORDS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        beat_en,
  input  logic [WORD_W-1:0]           beat_data,
  input  logic                        beat_err,
  output logic                        last_beat,
  output logic                        err_done,
  output logic                        ins_valid,
  output logic [WORD_W*INS_WORDS-1:0] ins_data
);
  localparam int BEAT_W = (INS_WORDS > 1) ? $clog2(INS_WORDS) : 1;
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(INS_WORDS-1);

  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              err_q, err_d, vld_d, vld_q, any_err;

  always_comb begin
    last_beat = beat_en && (beat_q == LAST_IDX);
    any_err   = err_q | (beat_en & beat_err);
    err_done  = last_beat & any_err;
    vld_d     = last_beat & ~any_err;
    beat_d    = last_beat ? '0 : beat_q + BEAT_W'(1);
    err_d     = last_beat ? 1'b0 : any_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (beat_en) begin
        beat_q <= beat_d;
        err_q  <= err_d;
      end
    end
  end

  for (genvar gi = 0; gi < INS_WORDS; gi++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (beat_en && (beat_q == BEAT_W'(gi))) word_q <= beat_data;
    end
    assign ins_data[gi*WORD_W +: WORD_W] = word_q;
  end

  assign ins_valid = vld_q;

  AST_INS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> $past(last_beat)); // R7
  AST_INS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> !ins_valid); // R7
endmodule

// File: rtl/iqf_fetch.sv
module iqf_fetch
  import iqf_pkg::*;
#(
  parameter int ADDR_W = 43,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [SIZE_W-1:0] seg_words,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_line,
  input  logic              credit_ok,
  input  logic              infl_full,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [ADDR_W-1:0] lnk_line,
  input  logic              ins_last,
  output logic              req_valid,
  output logic              req_ptr,
  output logic [ADDR_W-1:0] req_line,
  output logic              take_ins,
  output logic              ins_beat_en,
  output logic [ADDR_W-1:0] cur_line,
  output logic              rd_err
);
  localparam int SLOT_W = SIZE_W - 3;

  fetch_st_e         st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [SLOT_W-1:0] slot_q, slot_d, seg_n;
  logic [SIZE_W-1:0] seg_m1;
  logic              need_lnk, go, pos_en, err_d, err_q;

  always_comb begin
    seg_m1   = seg_words - SIZE_W'(1);
    seg_n    = SLOT_W'(seg_m1 >> 3);
    need_lnk = (slot_q == seg_n);
    go       = enable & credit_ok;
    st_d     = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (go && need_lnk)        st_d = ST_LNK_REQ;
        else if (go && !infl_full) st_d = ST_INS_REQ;
      end
      ST_INS_REQ: if (req_ready) st_d = ST_INS_RSP;
      ST_INS_RSP: if (ins_last)  st_d = ST_IDLE;
      ST_LNK_REQ: if (req_ready) st_d = ST_LNK_RSP;
      ST_LNK_RSP: if (rsp_valid) st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cur_d  = cur_q;
    slot_d = slot_q;
    pos_en = 1'b0;
    if (base_wr) begin
      cur_d  = base_line;
      slot_d = '0;
      pos_en = 1'b1;
    end else if ((st_q == ST_INS_RSP) && ins_last) begin
      cur_d  = cur_q + ADDR_W'(1);
      slot_d = slot_q + SLOT_W'(1);
      pos_en = 1'b1;
    end else if ((st_q == ST_LNK_RSP) && rsp_valid && !rsp_err) begin
      cur_d  = lnk_line;
      slot_d = '0;
      pos_en = 1'b1;
    end
  end

  always_comb begin
    req_valid   = (st_q == ST_INS_REQ) || (st_q == ST_LNK_REQ);
    req_ptr     = (st_q == ST_LNK_REQ);
    req_line    = cur_q;
    take_ins    = (st_q == ST_INS_REQ) && req_ready;
    ins_beat_en = (st_q == ST_INS_RSP) && rsp_valid;
    err_d       = rsp_valid && rsp_err &&
                  ((st_q == ST_INS_RSP) || (st_q == ST_LNK_RSP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      slot_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (pos_en) begin
        cur_q  <= cur_d;
        slot_q <= slot_d;
      end
    end
  end

  assign cur_line = cur_q;
  assign rd_err   = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line) && $stable(req_ptr))); // R11
  AST_BASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |-> (!enable && (st_q == ST_IDLE))); // R10
  AST_RSP_ONLY_WHEN_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((st_q == ST_INS_RSP) || (st_q == ST_LNK_RSP))); // R8
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_INS_RSP) && ins_last && !base_wr) |=> (cur_q == $past(cur_q) + ADDR_W'(1))); // R5
endmodule

// File: rtl/iqfetch_ctrl.sv
module iqfetch_ctrl #(
  parameter int CNT_W     = 20,
  parameter int SIZE_W    = 13,
  parameter int ADDR_W    = 43,
  parameter int WORD_W    = 64,
  parameter int INS_WORDS = 8,
  parameter int INFL_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic [SIZE_W-1:0]           seg_words,
  input  logic                        base_wr,
  input  logic [ADDR_W-1:0]           base_line,
  input  logic                        db_wr,
  input  logic [CNT_W-1:0]            db_val,
  input  logic                        ovf_clr,
  output logic                        req_valid,
  input  logic                        req_ready,
  output logic                        req_ptr,
  output logic [ADDR_W-1:0]           req_line,
  input  logic                        rsp_valid,
  input  logic [WORD_W-1:0]           rsp_data,
  input  logic                        rsp_err,
  output logic                        ins_valid,
  output logic [WORD_W*INS_WORDS-1:0] ins_data,
  input  logic                        ins_done,
  output logic [CNT_W-1:0]            pend_cnt,
  output logic [ADDR_W-1:0]           next_line,
  output logic [INFL_W-1:0]           inflight,
  output logic                        db_ovf,
  output logic                        rd_err
);
  localparam int LNK_LO = 6;
  localparam int LNK_HI = ADDR_W + LNK_LO - 1;

  logic rst_meta_q, rst_sync_q;
  logic credit_ok, infl_full, take_ins, ins_beat_en, ins_last, err_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  iqf_credit #(.CNT_W(CNT_W), .INS_WORDS(INS_WORDS)) u_credit (
    .clk(clk), .rst_n(rst_sync_q), .db_wr(db_wr), .db_val(db_val),
    .take(take_ins), .ovf_clr(ovf_clr), .cnt(pend_cnt), .ovf(db_ovf),
    .has_ins(credit_ok)
  );

  iqf_inflight #(.CNT_W(INFL_W)) u_infl (
    .clk(clk), .rst_n(rst_sync_q), .inc(take_ins), .dec_done(ins_done),
    .dec_err(err_done), .cnt(inflight), .full(infl_full)
  );

  iqf_fetch #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_fetch (
    .clk(clk), .rst_n(rst_sync_q), .enable(enable), .seg_words(seg_words),
    .base_wr(base_wr), .base_line(base_line), .credit_ok(credit_ok),
    .infl_full(infl_full), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .lnk_line(rsp_data[LNK_HI:LNK_LO]), .ins_last(ins_last),
    .req_valid(req_valid), .req_ptr(req_ptr), .req_line(req_line),
    .take_ins(take_ins), .ins_beat_en(ins_beat_en), .cur_line(next_line),
    .rd_err(rd_err)
  );

  iqf_assemble #(.WORD_W(WORD_W), .INS_WORDS(INS_WORDS)) u_asm (
    .clk(clk), .rst_n(rst_sync_q), .beat_en(ins_beat_en), .beat_data(rsp_data),
    .beat_err(rsp_err), .last_beat(ins_last), .err_done(err_done),
    .ins_valid(ins_valid), .ins_data(ins_data)
  );

  AST_FETCH_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(req_valid) |-> $past(enable && credit_ok)); // R4
endmodule

// File: tb/tb_iqfetch_ctrl.sv
module tb_iqfetch_ctrl;
  typedef struct packed {
    logic [42:0] line;
    logic        ptr;
    int          errbeat;
  } rq_t;

  logic         clk, rst_n, enable, base_wr, db_wr, ovf_clr, req_ready;
  logic         rsp_valid, rsp_err, ins_done;
  logic [12:0]  seg_words;
  logic [42:0]  base_line;
  logic [19:0]  db_val;
  logic [63:0]  rsp_data;
  logic         req_valid, req_ptr, ins_valid, db_ovf, rd_err;
  logic [42:0]  req_line, next_line;
  logic [511:0] ins_data;
  logic [19:0]  pend_cnt;
  logic [7:0]   inflight;

  iqfetch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .seg_words(seg_words),
    .base_wr(base_wr), .base_line(base_line), .db_wr(db_wr), .db_val(db_val),
    .ovf_clr(ovf_clr), .req_valid(req_valid), .req_ready(req_ready),
    .req_ptr(req_ptr), .req_line(req_line), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .ins_valid(ins_valid),
    .ins_data(ins_data), .ins_done(ins_done), .pend_cnt(pend_cnt),
    .next_line(next_line), .inflight(inflight), .db_ovf(db_ovf), .rd_err(rd_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rwait = 0, beat = 0;
  longint mpend = 0, pend_prev = 0;
  int  minfl = 0, infl_prev = 0, mslot = 0, mn = 4;
  bit  movf = 1'b0, exp_rd_err = 1'b0, en_prev = 1'b0, live = 1'b0;
  bit  prev_rv = 1'b0, prev_rr = 1'b0, prev_ptr = 1'b0;
  logic [42:0] mcur = '0, prev_line = '0;
  rq_t rq[$];
  logic [42:0] exp_ins[$];
  int  inj_ins_err = -1;
  bit  inj_lnk_err = 1'b0;
  int  ins_cnt = 0, err_cnt = 0, lnk_cnt = 0, req_cnt = 0, exp_ins_cnt = 0;

  function automatic logic [63:0] mword(logic [42:0] l, int w);
    return {l[39:0], 16'hBEEF, 8'(w)};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // reference model, updated at each rising edge
  always @(posedge clk) begin
    bit take, errdone;
    longint sum;
    int old;
    if (!live) begin
      prev_rv = 1'b0;
    end else begin
      take = req_valid && req_ready && !req_ptr;
      errdone = 1'b0;
      // R4: start conditions seen at the edge before the request rose
      if (req_valid && !prev_rv) begin
        chk(en_prev && pend_prev >= 8, "R4 start needs enable and credit", pend_prev, 8);
        if (!req_ptr) chk(infl_prev < 255, "R4 fetch needs inflight below 255", infl_prev, 254);
      end
      // R11: request held until accepted
      if (prev_rv && !prev_rr) begin
        chk(req_valid == 1'b1, "R11 request dropped", req_valid, 1);
        chk(req_line == prev_line && req_ptr == prev_ptr, "R11 request changed", req_line, prev_line);
      end
      en_prev = enable; pend_prev = mpend; infl_prev = minfl;
      prev_rv = req_valid; prev_rr = req_ready; prev_line = req_line; prev_ptr = req_ptr;
      if (req_valid && req_ready) begin
        rq_t r;
        req_cnt++;
        chk(req_ptr == (mslot == mn), "R6 link read position", req_ptr, (mslot == mn));
        chk(req_line == mcur, "R5 request line", req_line, mcur);
        r.line = req_line; r.ptr = req_ptr;
        if (req_ptr) begin
          lnk_cnt++;
          r.errbeat = inj_lnk_err ? 0 : -1;
          inj_lnk_err = 1'b0;
        end else begin
          r.errbeat = inj_ins_err;
          if (inj_ins_err < 0) begin exp_ins.push_back(req_line); exp_ins_cnt++; end
          inj_ins_err = -1;
        end
        rq.push_back(r);
      end
      exp_rd_err = rsp_valid && rsp_err;
      if (rsp_valid && rq.size() > 0) begin
        if (rq[0].ptr) begin
          if (!rsp_err) begin mcur = rq[0].line + 43'd100; mslot = 0; end
          void'(rq.pop_front()); beat = 0; rwait = 0;
        end else begin
          beat++;
          if (beat == 8) begin
            mcur = mcur + 43'd1; mslot++;
            errdone = (rq[0].errbeat >= 0);
            void'(rq.pop_front()); beat = 0; rwait = 0;
          end
        end
      end
      sum = mpend + (db_wr ? longint'(db_val) : 0) - (take ? 8 : 0);
      if (ovf_clr) movf = 1'b0;
      if (sum >= (64'd1 << 20)) movf = 1'b1;
      mpend = sum % (64'd1 << 20);
      old = minfl;
      minfl = old + (take ? 1 : 0) - ((ins_done && old > 0) ? 1 : 0) - (errdone ? 1 : 0);
      if (minfl < 0) minfl = 0;
      if (base_wr) begin mcur = base_line; mslot = 0; end
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    if (live) begin
      chk(pend_cnt == mpend[19:0], "R2 pending count", pend_cnt, mpend);
      chk(db_ovf == movf, "R3 overflow flag", db_ovf, movf);
      chk(inflight == minfl[7:0], "R9 inflight count", inflight, minfl);
      chk(next_line == mcur, "R5 next line readback", next_line, mcur);
      chk(rd_err == exp_rd_err, "R8 read error pulse", rd_err, exp_rd_err);
      if (rd_err) err_cnt++;
      if (ins_valid) begin
        ins_cnt++;
        if (exp_ins.size() == 0) chk(1'b0, "R7 unexpected instruction", 1, 0);
        else begin
          logic [511:0] e;
          logic [42:0] l;
          l = exp_ins.pop_front();
          for (int w = 0; w < 8; w++) e[64*w +: 64] = mword(l, w);
          chk(ins_data == e, "R7 instruction data", ins_data[63:0], e[63:0]);
        end
      end
    end
  end

  // memory responder
  initial begin
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      req_ready = (cyc % 4) != 0;
      rsp_valid = 1'b0; rsp_err = 1'b0;
      if (rq.size() > 0) begin
        if (rwait < 2) rwait++;
        else if ((cyc % 5) != 0) begin
          rsp_valid = 1'b1;
          if (rq[0].ptr) rsp_data = {15'h5555, rq[0].line + 43'd100, 6'h2A};
          else rsp_data = mword(rq[0].line, beat);
          rsp_err = (rq[0].errbeat == beat);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_test();
  end

  task automatic db(int v);
    @(negedge clk); db_wr = 1'b1; db_val = 20'(v);
    @(negedge clk); db_wr = 1'b0; db_val = '0;
  endtask

  task automatic wait_ins(int target, int limit);
    for (int i = 0; i < limit && ins_cnt < target; i++) @(negedge clk);
  endtask

  task automatic ack(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); ins_done = 1'b1;
      @(negedge clk); ins_done = 1'b0;
    end
  endtask

  task automatic reload(logic [42:0] b, int seg);
    @(negedge clk); enable = 1'b0;
    repeat (30) @(negedge clk);
    ack(int'(inflight));
    seg_words = 13'(seg); mn = (seg - 1) / 8;
    @(negedge clk); base_wr = 1'b1; base_line = b;
    @(negedge clk); base_wr = 1'b0;
  endtask

  initial begin
    int r0, l0, e0, i0;
    rst_n = 1'b0; enable = 1'b0; base_wr = 1'b0; db_wr = 1'b0; ovf_clr = 1'b0;
    ins_done = 1'b0; seg_words = 13'd33; base_line = '0; db_val = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(pend_cnt == 0 && db_ovf == 0, "R1 credit reset", pend_cnt, 0);
    chk(inflight == 0 && next_line == 0, "R1 position reset", next_line, 0);
    chk(!req_valid && !ins_valid && !rd_err, "R1 outputs idle", req_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    // R10 and R4: load start line, credit while disabled gives no read
    reload(43'd1000, 33);
    db(16);
    repeat (20) @(negedge clk);
    chk(req_cnt == 0, "R4 no read while disabled", req_cnt, 0);
    chk(next_line == 43'd1000, "R10 start line loaded", next_line, 1000);

    // R5 R7: two instructions, then credit runs out
    @(negedge clk); enable = 1'b1;
    wait_ins(2, 300);
    repeat (20) @(negedge clk);
    chk(ins_cnt == 2 && req_cnt == 2, "R4 stop when credit below 8", req_cnt, 2);
    ack(2);

    // R6 R2: segment crossings with doorbells during fetching
    db(80);
    repeat (15) @(negedge clk);
    db(24);
    wait_ins(15, 1500);
    chk(ins_cnt == 15, "R6 fetch across segments", ins_cnt, 15);
    chk(lnk_cnt >= 3, "R6 link reads issued", lnk_cnt, 3);
    ack(13);

    // R8: errored instruction dropped, line still consumed
    e0 = err_cnt; i0 = ins_cnt; l0 = int'(next_line);
    inj_ins_err = 3;
    db(8);
    repeat (60) @(negedge clk);
    chk(err_cnt == e0 + 1, "R8 error pulse on instruction", err_cnt, e0 + 1);
    chk(ins_cnt == i0, "R8 errored instruction not delivered", ins_cnt, i0);
    chk(inflight == 0, "R9 errored instruction retired", inflight, 0);

    // R8 R6: errored link read retried, seg of one instruction
    reload(43'd2000, 9);
    e0 = err_cnt; l0 = lnk_cnt; i0 = ins_cnt;
    inj_lnk_err = 1'b1;
    @(negedge clk); enable = 1'b1;
    db(24);
    wait_ins(i0 + 3, 600);
    repeat (10) @(negedge clk);
    chk(lnk_cnt == l0 + 3, "R8 link read reissued", lnk_cnt, l0 + 3);
    chk(err_cnt == e0 + 1, "R8 error pulse on link", err_cnt, e0 + 1);
    chk(next_line == 43'd2203, "R6 link low bits ignored", next_line, 2203);

    // R3: overflow, sticky, set wins over clear
    reload(43'd2500, 33);
    db(16);
    db(20'hFFFF8);
    chk(pend_cnt == 8 && db_ovf == 1'b1, "R3 overflow wraps and flags", pend_cnt, 8);
    db(8);
    chk(db_ovf == 1'b1, "R3 flag sticky", db_ovf, 1);
    @(negedge clk); db_wr = 1'b1; db_val = 20'hFFFF0; ovf_clr = 1'b1;
    @(negedge clk); db_wr = 1'b0; db_val = '0; ovf_clr = 1'b0;
    chk(pend_cnt == 0 && db_ovf == 1'b1, "R3 set wins over clear", db_ovf, 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk(db_ovf == 1'b0, "R3 flag cleared", db_ovf, 0);

    // R9: in-flight saturation stalls fetching
    reload(43'd3000, 33);
    i0 = ins_cnt;
    db(2080);
    @(negedge clk); enable = 1'b1;
    wait_ins(i0 + 255, 8000);
    repeat (60) @(negedge clk);
    chk(inflight == 8'd255, "R9 inflight saturates", inflight, 255);
    chk(pend_cnt == 20'd40, "R9 credit left after stall", pend_cnt, 40);
    ack(1);
    repeat (60) @(negedge clk);
    chk(inflight == 8'd255 && pend_cnt == 20'd32, "R9 one retire frees one fetch", pend_cnt, 32);
    chk(ins_cnt == exp_ins_cnt, "R7 instruction count", ins_cnt, exp_ins_cnt);
    finish_test();
  end
endmodule